// File: doc/BRIEF.md
# Disk Spindle Power Controller

This block decides when a disk spindle is powered. It walks through five states: stopped, ramping up, spinning idle (ready), spinning while an access is in progress, and ramping down. While stopped, an I/O request or a predictive wake hint starts a ramp-up. Both ramps take a fixed number of clock cycles. Once it is spinning with no work, the drive waits for an inactivity timeout and then ramps down. The ideal fixed timeout is the break-even point where the energy spent spinning idle equals the energy of a ramp-down followed by a ramp-up.

A request that arrives while the spindle is ramping (in either direction) is held. When a ramp-down completes with a held request, a ramp-up starts at once, and that ramp-up ends in the access state. An optional adaptive mode moves the timeout by a fixed step at the end of each idle period. A request that ends the idle period raises it. An expiry lowers it. The result is clamped to configured bounds. When adaptive mode is off, the timeout follows the configuration input. One-cycle command pulses mark the start of each ramp.

Top module: `spindle_pm`

## Requirements
- R1: After reset the state is stopped (code 0), the ready flag is low, both command pulses are low and the timeout register is 0.
- R2: In the stopped state, an I/O request or a wake hint moves the state to ramping up on the next clock. The spin-up pulse is high for exactly the first cycle of that ramp.
- R3: Ramp-up lasts UP_CYC cycles. It then ends in the access state if any request was seen since the ramp was triggered, and in the ready state if only a hint was seen.
- R4: The ready flag is high exactly while the state is ready.
- R5: A request in the ready state moves to the access state on the next clock. access_done in the access state returns to ready. Requests during the access state have no effect.
- R6: With no request, the ready state lasts exactly T cycles and then moves to ramping down, with a one-cycle spin-down pulse. T is the current timeout, and a timeout of 0 acts as 1.
- R7: Ramp-down lasts DOWN_CYC cycles and then ends in the stopped state.
- R8: A request seen during ramp-down is held. The ramp-down then goes directly into a ramp-up (with a spin-up pulse), and that ramp-up ends in the access state.
- R9: With adaptive mode off, the timeout register takes the value of tout_cfg one cycle later.
- R10: With adaptive mode on, a request that ends a ready period adds tout_step, and an expiry subtracts tout_step (saturating at 0). Values above tout_max become tout_max, and values below tout_min become tout_min.
- R11: The state codes are stopped=0, ramping up=1, ready=2, access=3, ramping down=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | I/O request strobe |
| wake_hint | input | 1 | Predictive spin-up trigger |
| access_done | input | 1 | Current access finished |
| adapt_en | input | 1 | Enable adaptive timeout |
| tout_cfg | input | CNT_W | Fixed timeout in cycles |
| tout_min | input | CNT_W | Adaptive lower bound |
| tout_max | input | CNT_W | Adaptive upper bound |
| tout_step | input | CNT_W | Adaptive step |
| state_o | output | 3 | Current state code |
| io_ready | output | 1 | Ready for I/O |
| spinup_pulse | output | 1 | Spin-up command pulse |
| spindown_pulse | output | 1 | Spin-down command pulse |
| tout_cur | output | CNT_W | Timeout in effect |

## Verification
The hardest situation to reach is a request held across the boundary between a ramp-down and a ramp-up. To get there, the drive must finish an access, sit idle through a full timeout, and then see a request inside the short ramp-down window. The directed stimulus counts cycles from each state change so that it places a request two cycles into the ramp-down. A long random phase with frequent requests and small timeouts then lands on this boundary, and on timeout saturation, many more times, under a per-cycle reference model.

// File: rtl/spindle_pm_pkg.sv
package spindle_pm_pkg;

  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_RAMP_UP   = 3'd1,
    ST_READY     = 3'd2,
    ST_ACCESS    = 3'd3,
    ST_RAMP_DOWN = 3'd4
  } spin_st_e;

  // A zero timeout behaves as a single cycle of idling.
  function automatic logic [31:0] eff_tout(input logic [31:0] t);
    return (t == 32'd0) ? 32'd1 : t;
  endfunction

  // Step the timeout up or down, saturate at zero, then clamp to bounds.
  function automatic logic [31:0] tout_adjust(
    input logic [31:0] cur,
    input logic        up,
    input logic [31:0] step,
    input logic [31:0] lo,
    input logic [31:0] hi
  );
    logic [32:0] v;
    if (up) v = {1'b0, cur} + {1'b0, step};
    else if (cur < step) v = 33'd0;
    else v = {1'b0, cur - step};
    if (v > {1'b0, hi}) v = {1'b0, hi};
    if (v < {1'b0, lo}) v = {1'b0, lo};
    return v[31:0];
  endfunction

endpackage

// File: rtl/spindle_ramp_timer.sv
module spindle_ramp_timer #(
  parameter int LEN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);
  localparam int W = (LEN < 2) ? 1 : $clog2(LEN + 1);
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (active) cnt <= cnt + 1'b1;
    else             cnt <= '0;
  end

  assign done = active && (cnt == LAST);
endmodule

// File: rtl/spindle_idle_timer.sv
module spindle_idle_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_ready,
  input  logic             io_req,
  input  logic [CNT_W-1:0] tout,
  output logic             expire
);
  import spindle_pm_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [31:0]      lim;

  assign lim = eff_tout(32'(tout)) - 32'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (in_ready) cnt <= cnt + 1'b1;
    else               cnt <= '0;
  end

  assign expire = in_ready && !io_req && (32'(cnt) >= lim);
endmodule

// File: rtl/spindle_tout_adapt.sv
module spindle_tout_adapt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adapt_en,
  input  logic             ev_hit,
  input  logic             ev_expire,
  input  logic [CNT_W-1:0] tout_cfg,
  input  logic [CNT_W-1:0] tout_min,
  input  logic [CNT_W-1:0] tout_max,
  input  logic [CNT_W-1:0] tout_step,
  output logic [CNT_W-1:0] tout
);
  import spindle_pm_pkg::*;

  logic [31:0] adj;

  assign adj = tout_adjust(32'(tout), ev_hit, 32'(tout_step),
                           32'(tout_min), 32'(tout_max));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     tout <= '0;
    else if (!adapt_en)             tout <= tout_cfg;
    else if (ev_hit || ev_expire)   tout <= adj[CNT_W-1:0];
  end
endmodule

// File: rtl/spindle_fsm.sv
module spindle_fsm (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     io_req,
  input  logic                     wake_hint,
  input  logic                     access_done,
  input  logic                     up_done,
  input  logic                     down_done,
  input  logic                     idle_expire,
  output spindle_pm_pkg::spin_st_e st,
  output logic                     up_p,
  output logic                     down_p
);
  import spindle_pm_pkg::*;

  spin_st_e nxt;
  logic     pend, pend_n;

  always_comb begin
    nxt    = st;
    pend_n = pend;
    unique case (st)
      ST_OFF: begin
        pend_n = pend | io_req;
        if (io_req || wake_hint) nxt = ST_RAMP_UP;
      end
      ST_RAMP_UP: begin
        pend_n = pend | io_req;
        if (up_done) begin
          nxt    = pend_n ? ST_ACCESS : ST_READY;
          pend_n = 1'b0;
        end
      end
      ST_READY: begin
        if (io_req)           nxt = ST_ACCESS;
        else if (idle_expire) nxt = ST_RAMP_DOWN;
      end
      ST_ACCESS: begin
        if (access_done) nxt = ST_READY;
      end
      ST_RAMP_DOWN: begin
        pend_n = pend | io_req;
        if (down_done) nxt = pend_n ? ST_RAMP_UP : ST_OFF;
      end
      default: nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_OFF;
      pend   <= 1'b0;
      up_p   <= 1'b0;
      down_p <= 1'b0;
    end else begin
      st     <= nxt;
      pend   <= pend_n;
      up_p   <= (nxt == ST_RAMP_UP)   && (st != ST_RAMP_UP);
      down_p <= (nxt == ST_RAMP_DOWN) && (st != ST_RAMP_DOWN);
    end
  end
endmodule

// File: rtl/spindle_pm.sv
module spindle_pm #(
  parameter int CNT_W    = 12,
  parameter int UP_CYC   = 10,
  parameter int DOWN_CYC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req,
  input  logic             wake_hint,
  input  logic             access_done,
  input  logic             adapt_en,
  input  logic [CNT_W-1:0] tout_cfg,
  input  logic [CNT_W-1:0] tout_min,
  input  logic [CNT_W-1:0] tout_max,
  input  logic [CNT_W-1:0] tout_step,
  output logic [2:0]       state_o,
  output logic             io_ready,
  output logic             spinup_pulse,
  output logic             spindown_pulse,
  output logic [CNT_W-1:0] tout_cur
);
  import spindle_pm_pkg::*;

  spin_st_e st;
  logic     up_done, down_done, idle_expire;
  logic     ev_idle_hit, ev_idle_expire;
  logic     in_ready;

  assign in_ready       = (st == ST_READY);
  assign ev_idle_hit    = in_ready && io_req;
  assign ev_idle_expire = idle_expire;

  spindle_ramp_timer #(.LEN(UP_CYC)) u_up_tmr (
    .clk(clk), .rst_n(rst_n), .active(st == ST_RAMP_UP), .done(up_done));

  spindle_ramp_timer #(.LEN(DOWN_CYC)) u_dn_tmr (
    .clk(clk), .rst_n(rst_n), .active(st == ST_RAMP_DOWN), .done(down_done));

  spindle_idle_timer #(.CNT_W(CNT_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .io_req(io_req),
    .tout(tout_cur), .expire(idle_expire));

  spindle_tout_adapt #(.CNT_W(CNT_W)) u_adapt (
    .clk(clk), .rst_n(rst_n), .adapt_en(adapt_en),
    .ev_hit(ev_idle_hit), .ev_expire(ev_idle_expire),
    .tout_cfg(tout_cfg), .tout_min(tout_min), .tout_max(tout_max),
    .tout_step(tout_step), .tout(tout_cur));

  spindle_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .wake_hint(wake_hint),
    .access_done(access_done), .up_done(up_done), .down_done(down_done),
    .idle_expire(idle_expire), .st(st), .up_p(spinup_pulse),
    .down_p(spindown_pulse));

  assign state_o  = st;
  assign io_ready = in_ready;
endmodule

// File: rtl/spindle_pm_chk.sv
module spindle_pm_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_req,
  input logic             wake_hint,
  input logic             access_done,
  input logic             adapt_en,
  input logic [CNT_W-1:0] tout_min,
  input logic [CNT_W-1:0] tout_max,
  input logic [2:0]       state_o,
  input logic             spinup_pulse,
  input logic             spindown_pulse,
  input logic [CNT_W-1:0] tout_cur,
  input logic             ev_idle_hit,
  input logic             ev_idle_expire
);
  p_wake_from_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && (io_req || wake_hint)) |=> (state_o == 3'd1));

  p_upcmd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spinup_pulse |=> !spinup_pulse);

  p_upcmd_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spinup_pulse) |-> (state_o == 3'd1));

  p_req_to_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idle_hit |=> (state_o == 3'd3));

  p_done_to_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && access_done) |=> (state_o == 3'd2));

  p_expire_downcmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idle_expire |=> (spindown_pulse && state_o == 3'd4));

  p_cmd_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(spinup_pulse && spindown_pulse));

  p_legal_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd4);

  p_tout_bounds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(adapt_en) && ($past(ev_idle_hit) || $past(ev_idle_expire)) &&
     $past(tout_min) <= $past(tout_max))
    |-> (tout_cur >= $past(tout_min) && tout_cur <= $past(tout_max)));
endmodule

bind spindle_pm spindle_pm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_req(io_req), .wake_hint(wake_hint),
  .access_done(access_done), .adapt_en(adapt_en), .tout_min(tout_min),
  .tout_max(tout_max), .state_o(state_o), .spinup_pulse(spinup_pulse),
  .spindown_pulse(spindown_pulse), .tout_cur(tout_cur),
  .ev_idle_hit(ev_idle_hit), .ev_idle_expire(ev_idle_expire));

// File: tb/spindle_pm_tb.sv
module spindle_pm_tb;
  localparam int CW = 12;
  localparam int UP = 10;
  localparam int DN = 6;

  logic clk = 0, rst_n = 0;
  logic io_req = 0, wake_hint = 0, access_done = 0, adapt_en = 0;
  logic [CW-1:0] tout_cfg = 20, tout_min = 0, tout_max = 0, tout_step = 0;
  logic [2:0] state_o;
  logic io_ready, spinup_pulse, spindown_pulse;
  logic [CW-1:0] tout_cur;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spindle_pm #(.CNT_W(CW), .UP_CYC(UP), .DOWN_CYC(DN)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .wake_hint(wake_hint),
    .access_done(access_done), .adapt_en(adapt_en), .tout_cfg(tout_cfg),
    .tout_min(tout_min), .tout_max(tout_max), .tout_step(tout_step),
    .state_o(state_o), .io_ready(io_ready), .spinup_pulse(spinup_pulse),
    .spindown_pulse(spindown_pulse), .tout_cur(tout_cur));

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model, behavioural, advanced on each rising edge
  int m_st, m_pend, m_up, m_dn, m_idle, m_tout, m_upp, m_dnp;

  function automatic int clampi(input int v, input int lo, input int hi);
    int r = v;
    if (r < 0) r = 0;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_pend = 0; m_up = 0; m_dn = 0; m_idle = 0;
      m_tout = 0; m_upp = 0; m_dnp = 0;
    end else begin
      int ns, lim;
      bit hit, exp_ev;
      ns = m_st; hit = 0; exp_ev = 0;
      lim = (m_tout == 0) ? 1 : m_tout;
      case (m_st)
        0: begin
          if (io_req) m_pend = 1;
          if (io_req || wake_hint) ns = 1;
        end
        1: begin
          if (io_req) m_pend = 1;
          if (m_up == UP - 1) begin ns = m_pend ? 3 : 2; m_pend = 0; end
        end
        2: begin
          if (io_req) begin ns = 3; hit = 1; end
          else if (m_idle + 1 >= lim) begin ns = 4; exp_ev = 1; end
        end
        3: if (access_done) ns = 2;
        default: begin
          if (io_req) m_pend = 1;
          if (m_dn == DN - 1) ns = m_pend ? 1 : 0;
        end
      endcase
      m_up   = (m_st == 1) ? m_up + 1 : 0;
      m_dn   = (m_st == 4) ? m_dn + 1 : 0;
      m_idle = (m_st == 2) ? m_idle + 1 : 0;
      if (!adapt_en) m_tout = tout_cfg;
      else if (hit)    m_tout = clampi(m_tout + tout_step, tout_min, tout_max);
      else if (exp_ev) m_tout = clampi(m_tout - tout_step, tout_min, tout_max);
      m_upp = (ns == 1 && m_st != 1);
      m_dnp = (ns == 4 && m_st != 4);
      m_st  = ns;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R11 state", state_o, m_st);
    chk("R4 ready", io_ready, m_st == 2);
    chk("R2 spinup", spinup_pulse, m_upp);
    chk("R6 spindown", spindown_pulse, m_dnp);
    chk("R10 timeout", tout_cur, m_tout);
  end

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic strobe_req();
    @(negedge clk) io_req = 1;
    @(negedge clk) io_req = 0;
  endtask

  task automatic strobe_hint();
    @(negedge clk) wake_hint = 1;
    @(negedge clk) wake_hint = 0;
  endtask

  task automatic strobe_done();
    @(negedge clk) access_done = 1;
    @(negedge clk) access_done = 0;
  endtask

  task automatic dwell(output int n);
    logic [2:0] s0 = state_o;
    n = 0;
    while (state_o == s0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    int n;
    cyc(3);
    chk("R1 reset state", state_o, 0);
    chk("R1 reset ready", io_ready, 0);
    chk("R1 reset pulses", spinup_pulse | spindown_pulse, 0);
    chk("R1 reset timeout", tout_cur, 0);
    rst_n = 1;
    cyc(2);
    chk("R9 cfg follows", tout_cur, 20);

    // hint-only wake
    strobe_hint();
    chk("R2 ramp entered", state_o, 1);
    chk("R2 pulse", spinup_pulse, 1);
    dwell(n);
    chk("R3 ramp-up length", n, UP);
    chk("R3 hint ends ready", state_o, 2);
    chk("R4 ready high", io_ready, 1);

    strobe_req();
    chk("R5 req to access", state_o, 3);
    strobe_req();
    chk("R5 req in access ignored", state_o, 3);
    strobe_done();
    chk("R5 done to ready", state_o, 2);

    dwell(n);
    chk("R6 idle length", n, 20);
    chk("R6 enters ramp-down", state_o, 4);
    chk("R6 spindown pulse", spindown_pulse, 1);
    dwell(n);
    chk("R7 ramp-down length", n, DN);
    chk("R7 ends stopped", state_o, 0);

    // request wake ends in access
    strobe_req();
    dwell(n);
    chk("R3 ramp-up length req", n, UP);
    chk("R3 req ends access", state_o, 3);
    strobe_done();
    dwell(n);
    chk("R6 reaches ramp-down", state_o, 4);
    cyc(1);
    strobe_req();
    dwell(n);
    chk("R8 ramp-down length", n, DN - 3);
    chk("R8 direct ramp-up", state_o, 1);
    chk("R8 spinup pulse", spinup_pulse, 1);
    dwell(n);
    chk("R8 ends access", state_o, 3);

    tout_cfg = 0;
    strobe_done();
    dwell(n);
    chk("R6 zero timeout one cycle", n, 1);
    dwell(n);
    chk("R7 stopped again", state_o, 0);
    @(negedge clk) tout_cfg = 7;
    @(negedge clk);
    chk("R9 timeout follows cfg", tout_cur, 7);

    // adaptive
    strobe_hint();
    dwell(n);
    @(negedge clk) begin
      tout_min = 4; tout_max = 12; tout_step = 5; adapt_en = 1;
    end
    strobe_req();
    chk("R10 step up", tout_cur, 12);
    strobe_done();
    strobe_req();
    chk("R10 clamp max", tout_cur, 12);
    strobe_done();
    dwell(n);
    chk("R10 idle uses 12", n, 12);
    chk("R10 step down", tout_cur, 7);
    dwell(n);
    strobe_hint();
    dwell(n);
    dwell(n);
    chk("R10 idle uses 7", n, 7);
    chk("R10 clamp min", tout_cur, 4);

    // random phase against model
    tout_min = 2; tout_max = 25;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      io_req      = ($urandom_range(0, 5) == 0);
      wake_hint   = ($urandom_range(0, 19) == 0);
      access_done = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 99) == 0) adapt_en = ~adapt_en;
      if ($urandom_range(0, 49) == 0) tout_cfg = CW'($urandom_range(0, 30));
      tout_step = CW'($urandom_range(1, 6));
    end
    io_req = 0; wake_hint = 0; access_done = 0;
    cyc(2);
    finished = 1;
    finish_run();
  end
endmodule